// File: doc/BRIEF.md
# Scoreboard Hazard Issue Check

This block sits at the issue stage of an in-order pipeline that feeds four functional units: integer, add, multiply and divide. Every cycle it may be offered one decoded instruction. The instruction carries an operation class that names its unit, one destination register and two source registers. The block decides in that same cycle whether the instruction may dispatch. It keeps two pieces of state. The first is a pending-write bit for each architectural register. The second is a busy bit for each functional unit.

An issue marks the destination register as pending. The bit stays set until a writeback port reports that register with its valid flag raised. Each functional unit owns one writeback port, and the port carries the destination index and write-valid pair that travel down that unit's pipeline. Units that cannot accept back-to-back work become busy when an instruction issues to them. They become free when they raise their completion strobe. The block stalls on a busy unit, on a source operand that is still waiting for a write (RAW), and on a destination that already has a write outstanding (WAW). Operands are read in order at issue, so write-after-read ordering is never checked.

Top module: `sb_issue_top`

## Requirements
- R1: With `in_valid` high and no hazard, `issue_grant` is 1 and `issue_stall` is 0 in the same cycle. `issue_unit` always equals `in_class`, encoded as 0 integer, 1 add, 2 multiply and 3 divide.
- R2: An instruction whose `in_src1` or `in_src2` names a pending register gets `issue_stall`=1 and `issue_grant`=0.
- R3: An instruction whose `in_dest` names a pending register gets `issue_stall`=1 and `issue_grant`=0.
- R4: A grant to a unit whose bit in `PIPE_MASK` is 0 marks that unit busy from the next cycle, and requests for a busy unit stall. Units whose bit is 1 never become busy. The default mask is 4'b0011, so multiply and divide are the blocking units.
- R5: A grant with a non-zero destination makes that register pending from the next cycle.
- R6: A writeback port with its valid bit high clears the pending bit of its register from the next cycle. A port with its valid bit low changes nothing.
- R7: If a grant sets a register in the same cycle that a writeback clears it, the register stays pending.
- R8: Register 0 never becomes pending, so naming it as a source or a destination never causes a stall.
- R9: With `in_valid` low, `issue_grant` and `issue_stall` are both 0 and no state changes.
- R10: After reset no register is pending and no unit is busy.
- R11: A completion strobe on a busy unit frees it from the next cycle. A request in the cycle of the strobe still stalls.
- R12: An instruction that writes a register still being read by an older, already issued instruction is not stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_class | input | 2 | Functional unit required (0 int, 1 add, 2 mul, 3 div) |
| in_dest | input | REG_W | Destination register index |
| in_src1 | input | REG_W | First source register index |
| in_src2 | input | REG_W | Second source register index |
| wb_valid | input | NUM_UNITS | Write-valid flag per unit writeback port |
| wb_dest | input | NUM_UNITS*REG_W | Destination index per writeback port, port u in bits [u*REG_W +: REG_W] |
| unit_done | input | NUM_UNITS | Completion strobe per unit |
| issue_grant | output | 1 | Instruction dispatches this cycle |
| issue_stall | output | 1 | Instruction present but held |
| issue_unit | output | 2 | Unit selected for the instruction |

## Verification
The grant, stall and unit outputs are combinational and depend on the offered instruction, so the bench checks them in the cycle it drives them. It drives on the falling edge and samples shortly before the next rising edge. Every state effect appears exactly one rising edge later: a pending bit set or cleared, a unit marked busy or freed. Each such effect is therefore probed by the instruction offered in the following cycle. The bench's own register and unit model is advanced at the same rising edge, using only the grant it expected.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NUM_UNITS = 4;
    localparam int UNIT_W    = 2;

    typedef enum logic [UNIT_W-1:0] {
        U_INT = 2'd0,
        U_ADD = 2'd1,
        U_MUL = 2'd2,
        U_DIV = 2'd3
    } unit_e;
endpackage

// File: rtl/sb_pending_regs.sv
module sb_pending_regs #(
    parameter int NUM_REGS = 32,
    parameter int NUM_WB   = 4,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_en,
    input  logic [REG_W-1:0]        set_idx,
    input  logic [NUM_WB-1:0]       wb_valid,
    input  logic [NUM_WB*REG_W-1:0] wb_dest,
    output logic [NUM_REGS-1:0]     pend
);
    typedef struct packed {
        logic [NUM_REGS-1:0] pend;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clears first, so a same-cycle set overrides them
        for (int p = 0; p < NUM_WB; p++) begin
            if (wb_valid[p]) begin
                st_d.pend[wb_dest[p*REG_W +: REG_W]] = 1'b0;
            end
        end
        if (set_en) begin
            st_d.pend[set_idx] = 1'b1;
        end
        st_d.pend[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/sb_unit_busy.sv
module sb_unit_busy
    import sb_pkg::*;
#(
    parameter logic [NUM_UNITS-1:0] PIPE_MASK = 4'b0011
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [UNIT_W-1:0]    set_unit,
    input  logic [NUM_UNITS-1:0] done,
    output logic [NUM_UNITS-1:0] busy
);
    typedef struct packed {
        logic [NUM_UNITS-1:0] busy;
    } busy_state_t;

    busy_state_t st_d, st_q;
    logic [NUM_UNITS-1:0] blocking;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_kind
        if (PIPE_MASK[u]) begin : g_pipe
            assign blocking[u] = 1'b0;
        end else begin : g_block
            assign blocking[u] = 1'b1;
        end
    end

    always_comb begin
        st_d.busy = st_q.busy & ~done;
        if (set_en && blocking[set_unit]) begin
            st_d.busy[set_unit] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                 in_valid,
    input  logic [UNIT_W-1:0]    in_class,
    input  logic [REG_W-1:0]     in_dest,
    input  logic [REG_W-1:0]     in_src1,
    input  logic [REG_W-1:0]     in_src2,
    input  logic [NUM_REGS-1:0]  pend,
    input  logic [NUM_UNITS-1:0] busy,
    output logic                 grant,
    output logic                 stall
);
    logic struct_hz, raw_hz, waw_hz;

    always_comb begin
        struct_hz = busy[in_class];
        raw_hz    = pend[in_src1] | pend[in_src2];
        waw_hz    = pend[in_dest];
        grant     = in_valid & ~(struct_hz | raw_hz | waw_hz);
        stall     = in_valid & (struct_hz | raw_hz | waw_hz);
    end
endmodule

// File: rtl/sb_issue_top.sv
module sb_issue_top
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter logic [3:0] PIPE_MASK = 4'b0011,
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [1:0]                 in_class,
    input  logic [REG_W-1:0]           in_dest,
    input  logic [REG_W-1:0]           in_src1,
    input  logic [REG_W-1:0]           in_src2,
    input  logic [NUM_UNITS-1:0]       wb_valid,
    input  logic [NUM_UNITS*REG_W-1:0] wb_dest,
    input  logic [NUM_UNITS-1:0]       unit_done,
    output logic                       issue_grant,
    output logic                       issue_stall,
    output logic [1:0]                 issue_unit
);
    logic [NUM_REGS-1:0]  pend;
    logic [NUM_UNITS-1:0] busy;
    logic                 grant;
    logic                 dest_set;

    sb_hazard_check #(.NUM_REGS(NUM_REGS)) u_check (
        .in_valid (in_valid),
        .in_class (in_class),
        .in_dest  (in_dest),
        .in_src1  (in_src1),
        .in_src2  (in_src2),
        .pend     (pend),
        .busy     (busy),
        .grant    (grant),
        .stall    (issue_stall)
    );

    assign dest_set = grant && (in_dest != '0);

    sb_pending_regs #(.NUM_REGS(NUM_REGS), .NUM_WB(NUM_UNITS)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (dest_set),
        .set_idx  (in_dest),
        .wb_valid (wb_valid),
        .wb_dest  (wb_dest),
        .pend     (pend)
    );

    sb_unit_busy #(.PIPE_MASK(PIPE_MASK)) u_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (grant),
        .set_unit (in_class),
        .done     (unit_done),
        .busy     (busy)
    );

    assign issue_grant = grant;
    assign issue_unit  = unit_e'(in_class);
endmodule

// File: rtl/sb_issue_chk.sv
module sb_issue_chk #(
    parameter int NUM_REGS = 32,
    parameter logic [3:0] PIPE_MASK = 4'b0011,
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       in_class,
    input logic [REG_W-1:0] in_dest,
    input logic [REG_W-1:0] in_src1,
    input logic [REG_W-1:0] in_src2,
    input logic             issue_grant,
    input logic             issue_stall,
    input logic [1:0]       issue_unit
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_grant && issue_stall));

    p_unit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_unit == in_class);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!issue_grant && !issue_stall));

    p_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(issue_grant) && $past(in_dest) != '0 && in_valid
         && in_src1 == $past(in_dest)) |-> !issue_grant);

    p_waw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(issue_grant) && $past(in_dest) != '0 && in_valid
         && in_dest == $past(in_dest)) |-> issue_stall);

    p_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(issue_grant) && !PIPE_MASK[$past(in_class)] && in_valid
         && in_class == $past(in_class)) |-> issue_stall);

    p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (PIPE_MASK[0] && in_valid && in_class == 2'd0 && in_dest == '0
         && in_src1 == '0 && in_src2 == '0) |-> issue_grant);
endmodule

bind sb_issue_top sb_issue_chk #(.NUM_REGS(NUM_REGS), .PIPE_MASK(PIPE_MASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_class    (in_class),
    .in_dest     (in_dest),
    .in_src1     (in_src1),
    .in_src2     (in_src2),
    .issue_grant (issue_grant),
    .issue_stall (issue_stall),
    .issue_unit  (issue_unit)
);

// File: tb/sb_issue_top_tb.sv
`timescale 1ns/1ps
module sb_issue_top_tb;
    localparam int NREG = 32;
    localparam int RW   = 5;
    localparam int NU   = 4;
    localparam logic [3:0] PMASK = 4'b0011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] in_class = '0;
    logic [RW-1:0] in_dest = '0, in_src1 = '0, in_src2 = '0;
    logic [NU-1:0] wb_valid = '0;
    logic [NU*RW-1:0] wb_dest = '0;
    logic [NU-1:0] unit_done = '0;
    logic issue_grant, issue_stall;
    logic [1:0] issue_unit;

    int checks = 0;
    int errors = 0;
    logic [NREG-1:0] m_pend = '0;
    logic [NU-1:0]   m_busy = '0;

    always #2 clk = ~clk;

    sb_issue_top #(.NUM_REGS(NREG), .PIPE_MASK(PMASK)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_dest(in_dest), .in_src1(in_src1), .in_src2(in_src2),
        .wb_valid(wb_valid), .wb_dest(wb_dest), .unit_done(unit_done),
        .issue_grant(issue_grant), .issue_stall(issue_stall), .issue_unit(issue_unit)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one cycle: drive on falling edge, check before rising edge, advance model
    task automatic cyc(string tag, logic v, logic [1:0] c, logic [RW-1:0] d,
                       logic [RW-1:0] s1, logic [RW-1:0] s2,
                       logic [NU-1:0] wv, logic [NU*RW-1:0] wd, logic [NU-1:0] dn);
        logic eg;
        @(negedge clk);
        in_valid = v; in_class = c; in_dest = d; in_src1 = s1; in_src2 = s2;
        wb_valid = wv; wb_dest = wd; unit_done = dn;
        eg = v && !m_busy[c] && !m_pend[s1] && !m_pend[s2] && !m_pend[d];
        #1;
        chk(tag, "grant", int'(issue_grant), int'(eg));
        chk(tag, "stall", int'(issue_stall), int'(v && !eg));
        chk(tag, "unit",  int'(issue_unit),  int'(c));
        @(posedge clk);
        for (int p = 0; p < NU; p++)
            if (wv[p]) m_pend[wd[p*RW +: RW]] = 1'b0;
        if (eg && d != 0) m_pend[d] = 1'b1;
        m_pend[0] = 1'b0;
        m_busy = m_busy & ~dn;
        if (eg && !PMASK[c]) m_busy[c] = 1'b1;
    endtask

    task automatic idle(string tag);
        cyc(tag, 1'b0, 2'd0, '0, '0, '0, '0, '0, '0);
    endtask

    task automatic clear_reg(logic [RW-1:0] r);
        cyc("R6", 1'b0, 2'd1, r, r, r, 4'b0001, {15'd0, r}, '0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: every register clear and every unit free after reset
        for (int r = 0; r < NREG; r++)
            cyc("R10", 1'b1, 2'd0, '0, RW'(r), RW'(r), '0, '0, '0);
        cyc("R10", 1'b1, 2'd2, '0, '0, '0, '0, '0, 4'b0100);
        cyc("R10", 1'b1, 2'd3, '0, '0, '0, '0, '0, 4'b1000);
        idle("R9");

        // R5 R2 R3 R6 R9 sweep over every non-zero register
        for (int r = 1; r < NREG; r++) begin
            cyc("R5", 1'b1, 2'd0, RW'(r), '0, '0, '0, '0, '0);
            cyc("R2", 1'b1, 2'd1, '0, RW'(r), '0, '0, '0, '0);
            cyc("R2", 1'b1, 2'd1, '0, '0, RW'(r), '0, '0, '0);
            cyc("R3", 1'b1, 2'd1, RW'(r), '0, '0, '0, '0, '0);
            cyc("R9", 1'b0, 2'd0, RW'(r % 31 + 1), '0, '0, '0, '0, '0);
            cyc("R6", 1'b0, 2'd0, '0, '0, '0, 4'b0001 << (r % 4),
                {4{RW'(r)}}, '0);
            cyc("R6", 1'b1, 2'd1, '0, RW'(r), '0, '0, '0, '0);
        end

        // R12: a later writer of a register an older instruction reads
        cyc("R12", 1'b1, 2'd1, 5'd6, 5'd5, '0, '0, '0, '0);
        cyc("R12", 1'b1, 2'd0, 5'd5, '0, '0, '0, '0, '0);
        clear_reg(5'd5); clear_reg(5'd6);

        // R7: set and clear of the same register in one cycle
        cyc("R7", 1'b1, 2'd0, 5'd9, '0, '0, 4'b0001, {15'd0, 5'd9}, '0);
        cyc("R7", 1'b1, 2'd1, '0, 5'd9, '0, '0, '0, '0);
        // R6: writeback with valid low leaves register pending
        cyc("R6", 1'b0, 2'd0, '0, '0, '0, 4'b0000, {4{5'd9}}, '0);
        cyc("R6", 1'b1, 2'd1, '0, '0, 5'd9, '0, '0, '0);
        clear_reg(5'd9);
        cyc("R6", 1'b1, 2'd1, '0, 5'd9, '0, '0, '0, '0);

        // R4 R11: structural hazard on blocking units, none on pipelined
        for (int u = 0; u < NU; u++) begin
            cyc("R4", 1'b1, 2'(u), '0, '0, '0, '0, '0, '0);
            cyc("R4", 1'b1, 2'(u), '0, '0, '0, '0, '0, '0);
            cyc("R11", 1'b1, 2'(u), '0, '0, '0, '0, '0, 4'b0001 << u);
            cyc("R11", 1'b1, 2'(u), '0, '0, '0, '0, '0, '0);
            cyc("R11", 1'b0, 2'(u), '0, '0, '0, '0, '0, 4'b0001 << u);
        end

        // R8: register zero never pending
        cyc("R8", 1'b1, 2'd1, '0, '0, '0, '0, '0, '0);
        cyc("R8", 1'b1, 2'd1, '0, '0, '0, '0, '0, '0);

        // R1: dense mixed traffic over a small register window
        for (int i = 0; i < 3000; i++) begin
            logic [NU*RW-1:0] wd;
            logic [NU-1:0] wv, dn;
            for (int p = 0; p < NU; p++) begin
                wd[p*RW +: RW] = RW'($urandom % 8);
                wv[p] = ($urandom % 3) == 0;
                dn[p] = ($urandom % 3) == 0;
            end
            cyc("R1", ($urandom % 4) != 0, 2'($urandom % 4), RW'($urandom % 8),
                RW'($urandom % 8), RW'($urandom % 8), wv, wd, dn);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule